// File: doc/BRIEF.md
# Transmit Dominant Time-Out Guard

This block sits between the transmit-data line of a CAN protocol controller and the enable of the bus driver. It watches the transmit input, where low means dominant. If that input stays dominant for longer than a time-out window, the guard releases the driver, so that a stuck controller or a software fault cannot hold the whole network dominant. The time-out is counted in clock cycles by a parameter. The default of 45000 cycles gives 450 µs at 100 MHz, which sits inside the allowed 300 µs to 700 µs span.

The time-out is armed only by a falling edge of the transmit input. Once it has fired, only a recessive level on the input clears it. While the driver is held off, the split-termination common-mode bias stays enabled.

The block also combines the standby select and the thermal-shutdown flag into the final drive decisions:
- In standby the driver and the bias are off, and the bus is left weakly pulled down.
- In thermal shutdown the driver and the bias are off until the flag clears.
- An undriven transmit line counts as recessive.

Top module: `txd_dom_guard`

## Requirements
- R1: Counting the sample that sees the falling edge as the first, `timeout_o` rises at the clock edge that takes the TIMEOUT_CYC-th consecutive dominant sample of the effective transmit input.
- R2: If the effective transmit input is sampled recessive at or before the TIMEOUT_CYC-th sample, `timeout_o` does not rise. This includes a recessive level in the very cycle the window would have expired.
- R3: While `timeout_o` is 1, `drive_dom_o` and `drv_active_o` are 0. `timeout_o` falls at the first clock edge that samples a recessive effective input.
- R4: While `timeout_o` is 1 in normal mode without thermal shutdown, `split_en_o` stays 1.
- R5: With `stby_i`=1, `drive_dom_o`, `drv_active_o` and `split_en_o` are 0 whatever the transmit level. The next clock edge clears the timer and `timeout_o`. Standby counts as recessive, so a dominant input present when standby ends is taken as a falling edge.
- R6: With `therm_i`=1, `drive_dom_o`, `drv_active_o` and `split_en_o` are 0 in the same cycle. They return as soon as `therm_i` is 0. The timer keeps running through thermal shutdown.
- R7: With `txd_open_i`=1, the effective transmit input is recessive whatever the value of `txd_i`.
- R8: In normal mode without a fault or a time-out, `drive_dom_o` is the combinational inverse of the effective transmit input (1 = dominant), and `drv_active_o` and `split_en_o` are 1.
- R9: After reset, `timeout_o` is 0 and the previous transmit level is taken as recessive. A dominant input seen first after reset therefore arms the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from the controller, 0 = dominant |
| txd_open_i | input | 1 | 1 when the transmit line is undriven |
| stby_i | input | 1 | Standby select, 1 = standby |
| therm_i | input | 1 | Thermal-shutdown flag |
| drive_dom_o | output | 1 | 1 = drive the bus dominant |
| drv_active_o | output | 1 | Driver enabled |
| split_en_o | output | 1 | Split common-mode bias enabled |
| timeout_o | output | 1 | Driver held off by the dominant time-out |

## Verification
The hardest case to reach is the exact expiry boundary, where a recessive level arrives in the same cycle the window would close. Reaching it needs a dominant run of exactly TIMEOUT_CYC samples, and at the default length that is far too long to sweep. The bench therefore shrinks TIMEOUT_CYC to 8. It then sweeps every dominant run length from 1 to TIMEOUT_CYC+2 and checks the flag after every sample against the count of samples taken. Separate sequences enter standby and thermal shutdown in the middle of a run, and leave standby with the input already dominant.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;
  typedef enum logic [1:0] {
    DRV_REC_Z = 2'd0,
    DRV_DOM   = 2'd1,
    DRV_WEAK  = 2'd2,
    DRV_OFF   = 2'd3
  } drv_mode_e;
endpackage

// File: rtl/txd_edge_cond.sv
module txd_edge_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic txd_open_i,
  input  logic stby_i,
  output logic txd_rec_o,
  output logic fall_o
);
  logic txd_q;

  // undriven line reads recessive
  assign txd_rec_o = txd_i | txd_open_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     txd_q <= 1'b1;
    else if (stby_i) txd_q <= 1'b1;
    else             txd_q <= txd_rec_o;
  end

  assign fall_o = txd_q & ~txd_rec_o & ~stby_i;
endmodule

// File: rtl/dom_timer.sv
module dom_timer #(
  parameter int unsigned TIMEOUT_CYC = 45000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fall_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else if (fall_i) begin
      cnt_q   <= CW'(1);
      armed_q <= 1'b1;
    end else if (armed_q && !exp_q) begin
      if (cnt_q == LAST) begin
        exp_q   <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/drive_mux.sv
module drive_mux
  import txd_guard_pkg::*;
(
  input  logic txd_rec_i,
  input  logic stby_i,
  input  logic therm_i,
  input  logic expired_i,
  output logic drive_dom_o,
  output logic drv_active_o,
  output logic split_en_o
);
  drv_mode_e mode;

  always_comb begin
    if (stby_i)                    mode = DRV_WEAK;
    else if (therm_i || expired_i) mode = DRV_OFF;
    else if (!txd_rec_i)           mode = DRV_DOM;
    else                           mode = DRV_REC_Z;
  end

  assign drive_dom_o  = (mode == DRV_DOM);
  assign drv_active_o = (mode == DRV_DOM) || (mode == DRV_REC_Z);
  // bias stays on through a time-out, off in standby and thermal
  assign split_en_o   = !stby_i && !therm_i;
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned TIMEOUT_CYC = 45000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic txd_open_i,
  input  logic stby_i,
  input  logic therm_i,
  output logic drive_dom_o,
  output logic drv_active_o,
  output logic split_en_o,
  output logic timeout_o
);
  logic txd_rec, fall, expired;

  txd_edge_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txd_i      (txd_i),
    .txd_open_i (txd_open_i),
    .stby_i     (stby_i),
    .txd_rec_o  (txd_rec),
    .fall_o     (fall)
  );

  dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (stby_i | txd_rec),
    .fall_i    (fall),
    .expired_o (expired)
  );

  drive_mux u_mux (
    .txd_rec_i    (txd_rec),
    .stby_i       (stby_i),
    .therm_i      (therm_i),
    .expired_i    (expired),
    .drive_dom_o  (drive_dom_o),
    .drv_active_o (drv_active_o),
    .split_en_o   (split_en_o)
  );

  assign timeout_o = expired;
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic txd_open_i,
  input logic stby_i,
  input logic therm_i,
  input logic drive_dom_o,
  input logic drv_active_o,
  input logic split_en_o,
  input logic timeout_o
);
  a_r3_off_when_timed_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!drive_dom_o && !drv_active_o));

  a_r3_clear_on_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_i || txd_open_i) |=> !timeout_o);

  a_r4_split_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !stby_i && !therm_i) |-> split_en_o);

  a_r5_standby_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> !timeout_o);

  a_r5_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |-> (!drive_dom_o && !drv_active_o && !split_en_o));

  a_r6_thermal_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |-> (!drive_dom_o && !drv_active_o && !split_en_o));

  a_r7_open_no_dom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_open_i |-> !drive_dom_o);

  a_r1_rise_after_dom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(!txd_i && !txd_open_i && !stby_i));
endmodule

bind txd_dom_guard txd_dom_guard_chk u_chk (.*);

// File: tb/txd_dom_guard_bench.sv
`timescale 1ns/1ps
module txd_dom_guard_bench;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, txd_open = 1'b0, stby = 1'b0, therm = 1'b0;
  logic drive_dom, drv_active, split_en, timeout;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(T)) u_txd_dom_guard (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .txd_open_i(txd_open),
    .stby_i(stby), .therm_i(therm), .drive_dom_o(drive_dom),
    .drv_active_o(drv_active), .split_en_o(split_en), .timeout_o(timeout));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset timeout", timeout, 1'b0);
    rst_n = 1'b1;
    cyc();
    chk("R8 idle drive", drive_dom, 1'b0);
    chk("R8 idle active", drv_active, 1'b1);
    chk("R8 idle split", split_en, 1'b1);

    // R1/R2 sweep of dominant run lengths
    for (int n = 1; n <= T + 2; n++) begin
      txd = 1'b0;
      settle();
      chk("R8 dominant drive", drive_dom, 1'b1);
      for (int k = 1; k <= n; k++) begin
        cyc();
        chk((k >= T) ? "R1 timeout flag" : "R2 no early timeout", timeout, (k >= T));
        chk("R3 drive gated", drive_dom, (k < T));
        chk("R3 active gated", drv_active, (k < T));
        chk("R4 split kept", split_en, 1'b1);
      end
      txd = 1'b1;
      settle();
      chk("R8 recessive drive", drive_dom, 1'b0);
      cyc();
      chk("R3 cleared by recessive", timeout, 1'b0);
      chk("R3 active restored", drv_active, 1'b1);
      cyc();
    end

    // R5 standby mid-timeout and exit with dominant
    txd = 1'b0;
    repeat (T) cyc();
    chk("R1 timed out before standby", timeout, 1'b1);
    stby = 1'b1;
    settle();
    chk("R5 standby drive", drive_dom, 1'b0);
    chk("R5 standby active", drv_active, 1'b0);
    chk("R5 standby split", split_en, 1'b0);
    cyc();
    chk("R5 standby clears timeout", timeout, 1'b0);
    repeat (T + 2) cyc();
    chk("R5 no timer in standby", timeout, 1'b0);
    stby = 1'b0;
    settle();
    chk("R5 exit dominant drives", drive_dom, 1'b1);
    for (int k = 1; k <= T; k++) begin
      cyc();
      chk("R5 exit counts as edge", timeout, (k >= T));
    end
    txd = 1'b1;
    cyc();

    // R6 thermal
    therm = 1'b1;
    txd = 1'b0;
    settle();
    chk("R6 thermal drive", drive_dom, 1'b0);
    chk("R6 thermal active", drv_active, 1'b0);
    chk("R6 thermal split", split_en, 1'b0);
    repeat (3) cyc();
    therm = 1'b0;
    settle();
    chk("R6 recovered drive", drive_dom, 1'b1);
    chk("R6 recovered split", split_en, 1'b1);
    repeat (T - 3) cyc();
    chk("R6 timer ran in thermal", timeout, 1'b1);
    txd = 1'b1;
    cyc();
    chk("R3 cleared after thermal run", timeout, 1'b0);

    // R7 open line
    txd = 1'b0;
    txd_open = 1'b1;
    settle();
    chk("R7 open drive", drive_dom, 1'b0);
    repeat (T + 2) cyc();
    chk("R7 open no timeout", timeout, 1'b0);
    txd_open = 1'b0;
    repeat (T - 1) cyc();
    chk("R7 open then dominant arms", timeout, 1'b0);
    cyc();
    chk("R7 open then dominant times out", timeout, 1'b1);
    txd_open = 1'b1;
    cyc();
    chk("R7 open clears timeout", timeout, 1'b0);
    txd_open = 1'b0;
    txd = 1'b1;
    cyc();

    // R9 dominant straight after reset
    rst_n = 1'b0;
    txd = 1'b0;
    cyc();
    rst_n = 1'b1;
    repeat (T) cyc();
    chk("R9 dominant after reset arms", timeout, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule